// File: doc/BRIEF.md
# Input Capture Timer Channel

This block is one timer channel used to measure pulses. A counter advances on a chosen clock. The clock can be a tap of an internal prescaler running off the system clock, or one of three external clock lines. The count can be taken on the falling edge instead of the rising one, and it can be gated by an external line. Edges of the measured input A copy the counter into capture register A and then into capture register B, in that order. Each of the two loads has its own edge choice. Software can then work out pulse widths and periods from the two captured values.

A trigger always restarts the count from zero on the next counter clock edge. There are three trigger sources: a software command, a chosen edge of input A or input B, and a match between the counter and compare register C. Loading B can halt the counter clock, and a later trigger resumes it. Loading B can instead switch the clock off, and then only an enable command brings it back. Event flags collect in a status word that clears when it is read, and a level interrupt output reports any enabled flag.

Two state machines make up the control. The clock machine has the states CLK_OFF, CLK_RUN and CLK_HALT. Its transitions are:
- CLK_OFF to CLK_RUN on an enable command.
- CLK_RUN to CLK_OFF on a disable command, or on a B load while disable-on-B is set.
- CLK_RUN to CLK_HALT on a B load while stop-on-B is set.
- CLK_HALT to CLK_RUN on a trigger.
- CLK_HALT to CLK_OFF on a disable command.

The capture sequencer has the states SEQ_WAIT_A and SEQ_WAIT_B. It goes from SEQ_WAIT_A to SEQ_WAIT_B when A loads. It goes from SEQ_WAIT_B back to SEQ_WAIT_A when B loads, or on any trigger.

Top module: `cap_tmr_chan`

## Requirements
- R1: After reset the counter, capture A, capture B, compare C, mode, interrupt enable and status all read 0, and irq is 0. Register word addresses are: 0 command (write only, reads 0), 1 mode, 2 counter, 3 capture A, 4 capture B, 5 compare C, 6 status, 7 interrupt enable.
- R2: Mode bits [2:0] select the counter clock. Codes 0 to 4 select the system clock divided by 2, 8, 32, 128 and 1024. Codes 5, 6 and 7 select external clocks 0, 1 and 2. The counter advances only while the clock machine is in CLK_RUN. Command bit 0 enables the clock and command bit 1 disables it. Disable wins when both bits are set.
- R3: Setting mode bit 3 makes the counter advance on the falling edge of the selected clock rather than on its rising edge.
- R4: Mode bits [5:4] gate the count. Code 0 leaves the clock ungated. Codes 1, 2 and 3 let counts through only while external clock 0, 1 or 2 is high.
- R5: Mode bits [7:6] pick the edge of input A that loads capture A, and bits [9:8] pick the edge that loads capture B. The edge codes are 0 none, 1 rising, 2 falling and 3 either. B loads only after A has loaded since the last trigger or the last B load. A loads again only after B has loaded.
- R6: Status bit 5 records that A loaded and bit 6 records that B loaded. Status bit 1 (overrun) is set when a capture loads while that capture's loaded flag has not yet been cleared by a status read.
- R7: When mode bit 10 is set, a B load halts the counter. Status bit 16 stays 1 while halted. A trigger resumes counting.
- R8: When mode bit 11 is set, a B load switches the clock off and status bit 16 becomes 0. A trigger does not restart it. A later enable command resumes counting, and any trigger still pending then takes effect.
- R9: Command bit 2 is a software trigger. After any trigger, the next counter clock edge loads 0 instead of incrementing.
- R10: A counter clock edge that brings the counter equal to compare C sets status bit 4. The equivalent matches against capture A and capture B set bits 2 and 3. When mode bit 12 is set, a match with C is a trigger, so the following count edge loads 0.
- R11: Mode bits [14:13] select the external trigger edge, with the same codes as R5. Mode bit 15 selects input A (1) or input B (0) as the source. Such a trigger sets status bit 7.
- R12: A count edge taken at the all-ones value wraps the counter to 0 and sets status bit 0.
- R13: Reading status clears bits 0 to 7. Status bits 17 and 18 show the levels of input A and input B.
- R14: irq is high exactly while some status bit among bits 0 to 7 is set and its enable bit in the interrupt enable register is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status when addr is 6) |
| addr | input | 3 | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from addr |
| xclk | input | 3 | External clocks 0 to 2 |
| in_a | input | 1 | Measured input A |
| in_b | input | 1 | Input B, usable as trigger source |
| irq | output | 1 | Level interrupt |

## Verification
A write, command or trigger takes effect at the clock edge that samples it. A count happens at the edge that first sees the selected clock edge, which is one cycle after the bench drives it. A capture stores the counter value held at the edge where it sees the input edge. Read data follows addr combinationally, and the status clear takes place at the edge of the read. The bench drives every input on a falling edge of clk and samples on the next falling edge, so that each result is read one edge after its cause. Prescaler checks measure the count difference over a window that is an exact multiple of the divisor, so the phase of the prescaler does not matter.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;

    localparam int XC_N   = 3;
    localparam int MODE_W = 16;
    localparam int FLAG_W = 8;
    localparam int TAP_N  = 5;

    typedef enum logic [2:0] {
        A_CMD  = 3'd0,
        A_MODE = 3'd1,
        A_CNT  = 3'd2,
        A_CAPA = 3'd3,
        A_CAPB = 3'd4,
        A_CMPC = 3'd5,
        A_STAT = 3'd6,
        A_IEN  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        CLK_OFF  = 2'd0,
        CLK_RUN  = 2'd1,
        CLK_HALT = 2'd2
    } clk_state_e;

    typedef enum logic {
        SEQ_WAIT_A = 1'b0,
        SEQ_WAIT_B = 1'b1
    } seq_state_e;

    // Mode word, most significant field first (bit 15 down to bit 0).
    typedef struct packed {
        logic       trg_src;
        logic [1:0] trg_edge;
        logic       cmp_restart;
        logic       dis_on_b;
        logic       stop_on_b;
        logic [1:0] b_edge;
        logic [1:0] a_edge;
        logic [1:0] gate;
        logic       inv;
        logic [2:0] src;
    } mode_t;

    localparam int ST_OVF   = 0;
    localparam int ST_LOVR  = 1;
    localparam int ST_CMPA  = 2;
    localparam int ST_CMPB  = 3;
    localparam int ST_CMPC  = 4;
    localparam int ST_LDA   = 5;
    localparam int ST_LDB   = 6;
    localparam int ST_ETRG  = 7;
    localparam int ST_CLKON = 16;
    localparam int ST_LVLA  = 17;
    localparam int ST_LVLB  = 18;

    // Prescaler bit whose rising edge gives divide by 2, 8, 32, 128, 1024.
    function automatic int tap_bit(input int idx);
        return (idx == TAP_N - 1) ? 9 : 2 * idx;
    endfunction

    function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/cap_tmr_clk.sv
module cap_tmr_clk
    import cap_tmr_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      src,
    input  logic            inv,
    input  logic [1:0]      gate,
    input  logic [XC_N-1:0] xc,
    output logic            tick
);
    localparam int DIV_W = (PRE_W < 10) ? 10 : PRE_W;

    logic [DIV_W-1:0] div;
    logic [TAP_N-1:0] tap;
    logic             lvl, lvl_q, gate_ok, edge_seen;
    logic             unused_div;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div   <= '0;
            lvl_q <= 1'b0;
        end else begin
            div   <= div + 1'b1;
            lvl_q <= lvl;
        end
    end

    for (genvar i = 0; i < TAP_N; i++) begin : g_tap
        assign tap[i] = div[tap_bit(i)];
    end

    assign unused_div = ^div;

    always_comb begin
        unique case (src)
            3'd0: lvl = tap[0];
            3'd1: lvl = tap[1];
            3'd2: lvl = tap[2];
            3'd3: lvl = tap[3];
            3'd4: lvl = tap[4];
            3'd5: lvl = xc[0];
            3'd6: lvl = xc[1];
            default: lvl = xc[2];
        endcase
    end

    always_comb begin
        unique case (gate)
            2'd0: gate_ok = 1'b1;
            2'd1: gate_ok = xc[0];
            2'd2: gate_ok = xc[1];
            default: gate_ok = xc[2];
        endcase
    end

    assign edge_seen = inv ? (lvl_q & ~lvl) : (lvl & ~lvl_q);
    assign tick      = edge_seen & gate_ok;

    // R4: a closed gate lets no count through
    assert_gate_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate == 2'd1 && !xc[0]) |-> !tick);

endmodule

// File: rtl/cap_tmr_edge.sv
module cap_tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign lvl  = sig_q;
    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;

endmodule

// File: rtl/cap_tmr_ctl.sv
module cap_tmr_ctl
    import cap_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_en,
    input  logic cmd_dis,
    input  logic trig,
    input  logic a_req,
    input  logic b_req,
    input  logic stop_on_b,
    input  logic dis_on_b,
    output logic run,
    output logic clk_on,
    output logic load_a,
    output logic load_b
);
    clk_state_e clk_st, clk_nx;
    seq_state_e seq_st, seq_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_st <= CLK_OFF;
            seq_st <= SEQ_WAIT_A;
        end else begin
            clk_st <= clk_nx;
            seq_st <= seq_nx;
        end
    end

    always_comb begin
        clk_nx = clk_st;
        unique case (clk_st)
            CLK_OFF:  if (cmd_en && !cmd_dis) clk_nx = CLK_RUN;
            CLK_RUN: begin
                if (cmd_dis)                     clk_nx = CLK_OFF;
                else if (load_b && dis_on_b)     clk_nx = CLK_OFF;
                else if (load_b && stop_on_b)    clk_nx = CLK_HALT;
            end
            CLK_HALT: begin
                if (cmd_dis)   clk_nx = CLK_OFF;
                else if (trig) clk_nx = CLK_RUN;
            end
            default: clk_nx = CLK_OFF;
        endcase
    end

    always_comb begin
        seq_nx = seq_st;
        unique case (seq_st)
            SEQ_WAIT_A: if (!trig && a_req) seq_nx = SEQ_WAIT_B;
            SEQ_WAIT_B: begin
                if (trig)       seq_nx = SEQ_WAIT_A;
                else if (b_req) seq_nx = SEQ_WAIT_A;
            end
            default: seq_nx = SEQ_WAIT_A;
        endcase
    end

    always_comb begin
        run    = (clk_st == CLK_RUN);
        clk_on = (clk_st != CLK_OFF);
        load_a = (seq_st == SEQ_WAIT_A) && a_req;
        load_b = (seq_st == SEQ_WAIT_B) && b_req;
    end

    // R2: disable command always ends in CLK_OFF
    assert_disable_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dis |=> (clk_st == CLK_OFF));

    // R7: B load with stop option halts a running clock
    assert_halt_on_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_st == CLK_RUN && load_b && stop_on_b && !dis_on_b && !cmd_dis) |=> (clk_st == CLK_HALT));

    // R8: an off clock stays off without an enable, triggers notwithstanding
    assert_off_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_st == CLK_OFF && !cmd_en) |=> (clk_st == CLK_OFF));

    // R5: after an A load without trigger, the next load can only be B
    assert_a_then_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a && !trig) |=> !load_a);

endmodule

// File: rtl/cap_tmr_chan.sv
module cap_tmr_chan
    import cap_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [XC_N-1:0]   xclk,
    input  logic              in_a,
    input  logic              in_b,
    output logic              irq
);
    localparam int DW_MIN = (CNT_W > ST_LVLB + 1) ? CNT_W : ST_LVLB + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    mode_t              mode;
    logic [CNT_W-1:0]   cnt, cap_a, cap_b, cmp_c, nxt;
    logic [FLAG_W-1:0]  flags, ien, evt;
    logic               trg_pend;
    logic [1:0]         pin, p_lvl, p_rise, p_fall;
    logic               tick, tick_run, run, clk_on, load_a, load_b;
    logic               wr_cmd, cmd_en, cmd_dis, sw_trg, ext_trg, rc_trg, trig;
    logic               hit_a, hit_b, hit_c, ovf_evt, lovr_evt, rd_stat;
    logic               unused_wdata;

    initial begin
        if (DATA_W < DW_MIN) $error("DATA_W too small for counter and status");
    end

    assign unused_wdata = ^wdata;

    cap_tmr_clk #(.PRE_W(PRE_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .src(mode.src), .inv(mode.inv),
        .gate(mode.gate), .xc(xclk), .tick(tick)
    );

    assign pin = {in_b, in_a};
    for (genvar i = 0; i < 2; i++) begin : g_pin
        cap_tmr_edge u_edge (
            .clk(clk), .rst_n(rst_n), .sig(pin[i]),
            .lvl(p_lvl[i]), .rise(p_rise[i]), .fall(p_fall[i])
        );
    end

    assign wr_cmd  = wr_en && (addr == A_CMD);
    assign cmd_en  = wr_cmd && wdata[0];
    assign cmd_dis = wr_cmd && wdata[1];
    assign sw_trg  = wr_cmd && wdata[2];
    assign rd_stat = rd_en && (addr == A_STAT);

    assign ext_trg = mode.trg_src ? edge_hit(mode.trg_edge, p_rise[0], p_fall[0])
                                  : edge_hit(mode.trg_edge, p_rise[1], p_fall[1]);

    assign tick_run = tick && run;
    assign nxt      = trg_pend ? '0 : cnt + 1'b1;
    assign hit_a    = tick_run && (nxt == cap_a);
    assign hit_b    = tick_run && (nxt == cap_b);
    assign hit_c    = tick_run && (nxt == cmp_c);
    assign rc_trg   = mode.cmp_restart && hit_c;
    assign trig     = sw_trg || ext_trg || rc_trg;
    assign ovf_evt  = tick_run && !trg_pend && (cnt == CNT_MAX);
    assign lovr_evt = (load_a && flags[ST_LDA]) || (load_b && flags[ST_LDB]);

    cap_tmr_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis), .trig(trig),
        .a_req(edge_hit(mode.a_edge, p_rise[0], p_fall[0])),
        .b_req(edge_hit(mode.b_edge, p_rise[0], p_fall[0])),
        .stop_on_b(mode.stop_on_b), .dis_on_b(mode.dis_on_b),
        .run(run), .clk_on(clk_on), .load_a(load_a), .load_b(load_b)
    );

    always_comb begin
        evt          = '0;
        evt[ST_OVF]  = ovf_evt;
        evt[ST_LOVR] = lovr_evt;
        evt[ST_CMPA] = hit_a;
        evt[ST_CMPB] = hit_b;
        evt[ST_CMPC] = hit_c;
        evt[ST_LDA]  = load_a;
        evt[ST_LDB]  = load_b;
        evt[ST_ETRG] = ext_trg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= '0;
            cmp_c <= '0;
            ien   <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_MODE:  mode  <= mode_t'(wdata[MODE_W-1:0]);
                A_CMPC:  cmp_c <= wdata[CNT_W-1:0];
                A_IEN:   ien   <= wdata[FLAG_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cap_a    <= '0;
            cap_b    <= '0;
            flags    <= '0;
            trg_pend <= 1'b0;
        end else begin
            if (tick_run) cnt <= nxt;
            if (load_a)   cap_a <= cnt;
            if (load_b)   cap_b <= cnt;
            if (trig)          trg_pend <= 1'b1;
            else if (tick_run) trg_pend <= 1'b0;
            flags <= (rd_stat ? '0 : flags) | evt;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CMD:  rdata = '0;
            A_MODE: rdata[MODE_W-1:0] = mode;
            A_CNT:  rdata[CNT_W-1:0]  = cnt;
            A_CAPA: rdata[CNT_W-1:0]  = cap_a;
            A_CAPB: rdata[CNT_W-1:0]  = cap_b;
            A_CMPC: rdata[CNT_W-1:0]  = cmp_c;
            A_STAT: begin
                rdata[FLAG_W-1:0] = flags;
                rdata[ST_CLKON]   = clk_on;
                rdata[ST_LVLA]    = p_lvl[0];
                rdata[ST_LVLB]    = p_lvl[1];
            end
            default: rdata[FLAG_W-1:0] = ien;
        endcase
    end

    assign irq = |(flags & ien);

    // R9: a pending trigger turns the next count edge into a zero load
    assert_trig_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_pend && tick && run) |=> (cnt == '0));

    // R2: the counter holds while the clock is not running
    assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));

    // R12: counting past all ones raises the overflow flag
    assert_ovf_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !trg_pend && cnt == CNT_MAX) |=> flags[ST_OVF]);

    // R13: a status read with no new event leaves all event flags clear
    assert_clear_on_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_STAT && evt == '0) |=> (flags == '0));

endmodule

// File: tb/tb_cap_tmr_chan.sv
`timescale 1ns/1ps
module tb_cap_tmr_chan;

    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  xclk = 3'b000;
    logic        in_a = 1'b0;
    logic        in_b = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int v, v0, v1, n1, n2, last_b;

    always #2.5 clk = ~clk;

    cap_tmr_chan #(.CNT_W(CW), .DATA_W(32), .PRE_W(10)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .xclk(xclk), .in_a(in_a), .in_b(in_b), .irq(irq)
    );

    function automatic int mode_w(int src, int inv, int gate, int ae, int be,
                                  int stop, int dis, int cmpr, int te, int ts);
        return src | (inv << 3) | (gate << 4) | (ae << 6) | (be << 8) | (stop << 10)
             | (dis << 11) | (cmpr << 12) | (te << 13) | (ts << 15);
    endfunction

    function automatic int divisor(int code);
        return (code == 4) ? 1024 : (2 << (2 * code));
    endfunction

    function automatic int wrap(int x);
        return x % (1 << CW);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[2:0]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input bit clr, output int d);
        @(negedge clk);
        addr = a[2:0]; rd_en = clr;
        #1 d = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic xtick(input int n);
        repeat (n) begin
            @(negedge clk); xclk[0] = 1'b1;
            @(negedge clk); xclk[0] = 1'b0;
        end
    endtask

    task automatic set_a(input logic val);
        @(negedge clk); in_a = val;
        @(negedge clk);
    endtask

    task automatic set_b(input logic val);
        @(negedge clk); in_b = val;
        @(negedge clk);
    endtask

    // count difference over a window of cyc cycles
    task automatic win(input int cyc, output int diff);
        int c0, c1;
        rd(2, 0, c0);
        repeat (cyc - 1) @(posedge clk);
        rd(2, 0, c1);
        diff = wrap(c1 - c0 + (1 << CW));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(6, 0, v); chk("R1 status", v, 0);
        rd(2, 0, v); chk("R1 counter", v, 0);
        rd(3, 0, v); chk("R1 capture A", v, 0);
        rd(1, 0, v); chk("R1 mode", v, 0);
        chk("R1 irq", irq, 0);

        // R2 clock off: no counting
        wr(1, mode_w(5, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        xtick(3);
        rd(2, 0, v); chk("R2 off holds", v, 0);
        wr(0, 1);
        rd(6, 0, v); chk("R2 clock on bit", (v >> 16) & 1, 1);
        xtick(5);
        rd(2, 0, v); chk("R2 ext clock count", v, 5);

        // R9 software trigger
        wr(0, 4);
        rd(2, 0, v); chk("R9 waits for edge", v, 5);
        xtick(1);
        rd(2, 0, v); chk("R9 zero after trigger", v, 0);
        xtick(3);
        rd(2, 0, v); chk("R9 counts again", v, 3);

        // R3 falling-edge counting
        wr(1, mode_w(5, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk); xclk[0] = 1'b1;
        rd(2, 0, v); chk("R3 rise ignored", v, 3);
        @(negedge clk); xclk[0] = 1'b0;
        rd(2, 0, v); chk("R3 fall counts", v, 4);

        // R2 prescaler taps
        for (int code = 0; code < 3; code++) begin
            wr(1, mode_w(code, 0, 0, 0, 0, 0, 0, 0, 0, 0));
            win(divisor(code) * 5, v);
            chk("R2 prescaler", v, 5);
        end

        // R4 gating by external clock 1
        wr(1, mode_w(0, 0, 2, 0, 0, 0, 0, 0, 0, 0));
        win(40, v); chk("R4 gate closed", v, 0);
        @(negedge clk); xclk[1] = 1'b1;
        win(40, v); chk("R4 gate open", v, 20);
        @(negedge clk); xclk[1] = 1'b0;

        // R5 random capture pairs
        wr(1, mode_w(5, 0, 0, 1, 2, 0, 0, 0, 0, 0));
        rd(6, 1, v);
        for (int it = 0; it < 8; it++) begin
            n1 = $urandom_range(0, 20);
            n2 = $urandom_range(1, 20);
            wr(0, 4);
            xtick(1);
            xtick(n1);
            set_a(1'b1);
            xtick(n2);
            set_a(1'b0);
            rd(3, 0, v); chk("R5 capture A", v, wrap(n1));
            rd(4, 0, v); chk("R5 capture B", v, wrap(n1 + n2));
            last_b = wrap(n1 + n2);
            rd(6, 1, v);
            chk("R6 loaded flags", (v >> 5) & 3, 3);
            chk("R6 no overrun", (v >> 1) & 1, 0);
        end

        // R5 B is not loaded before A
        rd(6, 1, v);
        wr(1, mode_w(5, 0, 0, 2, 1, 0, 0, 0, 0, 0));
        wr(0, 4);
        xtick(1); xtick(2);
        set_a(1'b1);
        xtick(3);
        rd(4, 0, v); chk("R5 B held before A", v, last_b);
        rd(6, 1, v); chk("R5 no loads yet", (v >> 5) & 3, 0);
        set_a(1'b0);
        xtick(2);
        set_a(1'b1);
        rd(3, 0, v); chk("R5 A on fall", v, 5);
        rd(4, 0, v); chk("R5 B on rise after A", v, 7);

        // R6 overrun on unread A
        set_a(1'b0);
        rd(6, 1, v);
        chk("R6 overrun set", (v >> 1) & 1, 1);
        chk("R6 A loaded set", (v >> 5) & 1, 1);
        rd(3, 0, v); chk("R6 A reloaded", v, 7);
        rd(6, 1, v); chk("R13 cleared by read", v & 8'hE3, 0);

        // R14 interrupt on B loaded
        wr(7, 1 << 6);
        chk("R14 irq idle", irq, 0);
        set_a(1'b1);
        #1 chk("R14 irq raised", irq, 1);
        rd(6, 1, v);
        #1 chk("R14 irq cleared", irq, 0);
        wr(7, 0);

        // R7 stop on B, trigger resumes
        wr(1, mode_w(5, 0, 0, 1, 2, 1, 0, 0, 0, 0));
        set_a(1'b0);
        wr(0, 4);
        xtick(1); xtick(2);
        set_a(1'b1);
        xtick(2);
        set_a(1'b0);
        xtick(3);
        rd(2, 0, v); chk("R7 halted", v, 4);
        rd(6, 1, v); chk("R7 clock still on", (v >> 16) & 1, 1);
        wr(0, 4);
        xtick(1);
        rd(2, 0, v); chk("R7 resumed zero", v, 0);
        xtick(2);
        rd(2, 0, v); chk("R7 resumed count", v, 2);

        // R8 disable on B
        wr(1, mode_w(5, 0, 0, 1, 2, 0, 1, 0, 0, 0));
        set_a(1'b1);
        xtick(1);
        set_a(1'b0);
        rd(6, 1, v); chk("R8 clock off bit", (v >> 16) & 1, 0);
        wr(0, 4);
        xtick(3);
        rd(2, 0, v); chk("R8 trigger no restart", v, 3);
        wr(0, 1);
        xtick(1);
        rd(2, 0, v); chk("R8 enable applies pending", v, 0);

        // R10 compare C restart
        wr(1, mode_w(5, 0, 0, 0, 0, 0, 0, 1, 0, 0));
        wr(5, 4);
        rd(6, 1, v);
        xtick(4);
        rd(2, 0, v); chk("R10 reached C", v, 4);
        rd(6, 0, v); chk("R10 compare C flag", (v >> 4) & 1, 1);
        xtick(1);
        rd(2, 0, v); chk("R10 restart zero", v, 0);
        xtick(1);
        rd(2, 0, v); chk("R10 counts after restart", v, 1);

        // R11 external trigger from A rising
        wr(1, mode_w(5, 0, 0, 0, 0, 0, 0, 0, 1, 1));
        xtick(2);
        rd(6, 1, v);
        set_a(1'b1);
        rd(6, 0, v); chk("R11 trigger flag", (v >> 7) & 1, 1);
        xtick(1);
        rd(2, 0, v); chk("R11 A trigger zero", v, 0);
        xtick(2);
        // R11 source B falling; A edges ignored
        wr(1, mode_w(5, 0, 0, 0, 0, 0, 0, 0, 2, 0));
        rd(6, 1, v);
        set_a(1'b0);
        xtick(1);
        rd(2, 0, v); chk("R11 A ignored", v, 3);
        rd(6, 0, v); chk("R11 no flag", (v >> 7) & 1, 0);
        set_b(1'b1);
        set_b(1'b0);
        xtick(1);
        rd(2, 0, v); chk("R11 B fall trigger", v, 0);

        // R13 input levels
        set_a(1'b1);
        set_b(1'b1);
        rd(6, 0, v); chk("R13 levels", (v >> 17) & 3, 3);

        // R12 overflow
        rd(6, 1, v);
        xtick((1 << CW) - 1);
        rd(2, 0, v0); chk("R12 at max", v0, (1 << CW) - 1);
        rd(6, 0, v); chk("R12 no flag yet", v & 1, 0);
        xtick(1);
        rd(2, 0, v1); chk("R12 wrapped", v1, 0);
        rd(6, 1, v); chk("R12 overflow flag", v & 1, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule